// File: doc/BRIEF.md
# Descriptor ring doorbell controller

This block keeps track of which entries of a circular descriptor queue belong to the hardware engine and which belong to software. Software posts new work by writing a count to an add doorbell. An execution stage, stubbed here as a pulse input, reports each finished descriptor. Software hands finished entries back by writing a count to a release doorbell. No descriptor is fetched from memory here. The block only holds the counts and the ring indices, and it tells the execution stage whether work is available and at which index.

A single status word packs two values: how many finished descriptors software has not yet released, and the ring index of the oldest one. A service routine reads that word, processes the entries it names and writes the count back to the release doorbell. The queue comes out of reset stopped and starts once software writes zero to the run-control register. A descriptor that finishes with its interrupt-request flag set raises an interrupt. The interrupt stays up while finished entries remain unreleased.

Top module: `dring_doorbell`

## Requirements
- R1: After reset the queue is stopped (run-control read bit 0 = 1), the status word (address 3) and the error word (address 5) read 0, the queue size (address 0) reads 0, and fetch_valid and irq are low.
- R2: A write to the add doorbell (address 1) adds its count to the outstanding work. fetch_valid is high exactly when the queue is running and outstanding work is non-zero. While fetch_valid is low, desc_done has no effect.
- R3: Each cycle with desc_done high while fetch_valid is high completes one descriptor. The outstanding work drops by one, fetch_idx advances by one and the pending-completion count rises by one. At most one descriptor completes per cycle.
- R4: The status word holds the pending-completion count in bits [14:0] and the index of the oldest unreleased descriptor in bits [28:16]. All other bits read 0.
- R5: A write to the release doorbell (address 2) subtracts its count from the pending-completion count and advances the oldest-unreleased index by the same amount.
- R6: fetch_idx and the oldest-unreleased index wrap modulo the programmed queue size.
- R7: A release count larger than the pending-completion count is clamped to that count and sets sticky error bit 1 of the error word.
- R8: Outstanding work plus pending completions never exceeds the queue size. An add count beyond the free slots is cut to the free slots and sets sticky error bit 0 of the error word.
- R9: A completion with done_ioc high arms the interrupt. irq is high only while the interrupt is armed and the pending-completion count is non-zero, and the interrupt disarms when that count reaches zero.
- R10: A write of 0 to run-control (address 4) starts the queue. A non-zero write stops it. Run-control reads back bit 0 = 1 while stopped, and no fetch is offered while stopped.
- R11: A queue size write (address 0) above 2^IDX_W entries is stored as 2^IDX_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Register read data, combinational |
| fetch_valid | output | 1 | Work is available to the execution stage |
| fetch_idx | output | IDX_W | Ring index of the next descriptor to execute |
| desc_done | input | 1 | One-cycle pulse: the current descriptor finished |
| done_ioc | input | 1 | The finishing descriptor requests an interrupt |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest states to reach are those where the ring is completely full and both indices have wrapped. At that point the add doorbell has to be cut to zero while the release pointer crosses the end of the ring. The stimulus programs a small ring of eight entries and walks both indices past the end. It then overfills the ring with two add writes, drains it with eight completions, and releases across the wrap point. Before that, an oversized release exercises the clamp.

// File: rtl/dbl_pkg.sv
// Shared definitions for the descriptor ring doorbell controller.
// Assumes a word-addressed register port of eight locations.
package dbl_pkg;
    typedef enum logic [2:0] {
        REG_SIZE = 3'd0,
        REG_ADD  = 3'd1,
        REG_FREE = 3'd2,
        REG_STAT = 3'd3,
        REG_RUN  = 3'd4,
        REG_ERR  = 3'd5
    } reg_addr_e;

    localparam int STAT_PEND_LSB = 0;
    localparam int STAT_IDX_LSB  = 16;
endpackage

// File: rtl/dbl_regs.sv
// Register decode: holds queue size and run state and produces doorbell strobes.
// Assumes one write per cycle. The size is clamped to 2^IDX_W entries.
module dbl_regs #(
    parameter int IDX_W = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [2:0]     wr_addr,
    input  logic [31:0]    wr_data,
    output logic [IDX_W:0] q_size,
    output logic           stopped,
    output logic           add_wr,
    output logic           free_wr
);
    import dbl_pkg::*;
    localparam logic [31:0] MAX_ENT = 32'(2 ** IDX_W);

    // Doorbell strobes decoded from the write port
    always_comb begin
        add_wr  = wr_en && (wr_addr == REG_ADD);
        free_wr = wr_en && (wr_addr == REG_FREE);
    end

    // Queue size and run-control state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_size  <= '0;
            stopped <= 1'b1;
        end else if (wr_en) begin
            if (wr_addr == REG_SIZE)
                q_size <= (wr_data > MAX_ENT) ? MAX_ENT[IDX_W:0] : wr_data[IDX_W:0];
            if (wr_addr == REG_RUN)
                stopped <= (wr_data != 32'd0);
        end
    end

    AST_SIZE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ({{(31-IDX_W){1'b0}}, q_size} <= MAX_ENT)); // R11
endmodule

// File: rtl/dbl_ptr.sv
// Ring index that moves forward by a step each cycle and wraps modulo the queue size.
// Assumes step <= size and index < size before the step.
module dbl_ptr #(
    parameter int IDX_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W:0]   step,
    input  logic [IDX_W:0]   size,
    output logic [IDX_W-1:0] ptr
);
    logic [IDX_W+1:0] sum;
    logic [IDX_W+1:0] wrapped;

    // Candidate next index with a single modulo correction
    always_comb begin
        sum     = {2'b00, ptr} + {1'b0, step};
        wrapped = (sum >= {1'b0, size}) ? (sum - {1'b0, size}) : sum;
    end

    // Index register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (step != '0)
            ptr <= wrapped[IDX_W-1:0];
    end
endmodule

// File: rtl/dbl_occ.sv
// Occupancy tracking: outstanding work, pending completions, error flags and interrupt arm.
// Assumes desc_done is a single-cycle pulse. The doorbell count comes from the write data.
module dbl_occ #(
    parameter int IDX_W = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [IDX_W:0] q_size,
    input  logic           stopped,
    input  logic           add_wr,
    input  logic           free_wr,
    input  logic [31:0]    wr_cnt,
    input  logic           desc_done,
    input  logic           done_ioc,
    output logic           fetch_valid,
    output logic           done_acc,
    output logic [IDX_W:0] free_step,
    output logic [IDX_W:0] pend,
    output logic [1:0]     err,
    output logic           irq
);
    localparam int CW = IDX_W + 1;

    logic [CW-1:0] outst;
    logic [CW:0]   used;
    logic [CW:0]   room;
    logic          add_big;
    logic          free_big;
    logic [CW:0]   add_amt;
    logic [CW-1:0] free_amt;
    logic [CW:0]   out_nx;
    logic [CW:0]   pend_nx;
    logic          irq_arm;

    // Work offer and accepted completion
    always_comb begin
        fetch_valid = !stopped && (outst != '0);
        done_acc    = desc_done && fetch_valid;
    end

    // Doorbell amounts after saturation and clamping
    always_comb begin
        used     = {1'b0, outst} + {1'b0, pend};
        room     = (used >= {1'b0, q_size}) ? '0 : ({1'b0, q_size} - used);
        add_big  = wr_cnt > {{(31-CW){1'b0}}, room};
        free_big = wr_cnt > {{(32-CW){1'b0}}, pend};
        add_amt  = !add_wr ? '0 : (add_big ? room : wr_cnt[CW:0]);
        free_amt = !free_wr ? '0 : (free_big ? pend : wr_cnt[CW-1:0]);
        out_nx   = {1'b0, outst} + add_amt - {{CW{1'b0}}, done_acc};
        pend_nx  = {1'b0, pend} + {{CW{1'b0}}, done_acc} - {1'b0, free_amt};
        free_step = free_amt;
    end

    // Counters, sticky errors and interrupt arm
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst   <= '0;
            pend    <= '0;
            err     <= 2'b00;
            irq_arm <= 1'b0;
        end else begin
            outst <= out_nx[CW-1:0];
            pend  <= pend_nx[CW-1:0];
            if (add_wr && add_big)
                err[0] <= 1'b1;
            if (free_wr && free_big)
                err[1] <= 1'b1;
            if (pend_nx == '0)
                irq_arm <= 1'b0;
            else if (done_acc && done_ioc)
                irq_arm <= 1'b1;
        end
    end

    // Interrupt output qualified by pending work
    always_comb irq = irq_arm && (pend != '0);

    AST_NO_FETCH_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> !fetch_valid); // R10
    AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !free_wr |=> ({1'b0, pend} <= {1'b0, $past(pend)} + 1'b1)); // R3
    AST_RING_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, outst} + {1'b0, pend}) <= (CW+1)'(2 ** IDX_W)); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err[0] |=> err[0]); // R8
    AST_CLAMP_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err[1] |=> err[1]); // R7
endmodule

// File: rtl/dring_doorbell.sv
// Top of the descriptor ring doorbell controller: register read mux plus two ring indices.
// Assumes combinational reads and one register write per cycle.
module dring_doorbell #(
    parameter int IDX_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [2:0]       rd_addr,
    output logic [31:0]      rd_data,
    output logic             fetch_valid,
    output logic [IDX_W-1:0] fetch_idx,
    input  logic             desc_done,
    input  logic             done_ioc,
    output logic             irq
);
    import dbl_pkg::*;

    logic [IDX_W:0]   q_size;
    logic             stopped;
    logic             add_wr;
    logic             free_wr;
    logic             done_acc;
    logic [IDX_W:0]   free_step;
    logic [IDX_W:0]   pend;
    logic [1:0]       err;
    logic [IDX_W-1:0] rel_idx;
    logic [IDX_W:0]   fetch_step;
    logic [31:0]      stat_word;

    dbl_regs #(.IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .q_size(q_size), .stopped(stopped),
        .add_wr(add_wr), .free_wr(free_wr)
    );

    dbl_occ #(.IDX_W(IDX_W)) u_occ (
        .clk(clk), .rst_n(rst_n), .q_size(q_size), .stopped(stopped),
        .add_wr(add_wr), .free_wr(free_wr), .wr_cnt(wr_data),
        .desc_done(desc_done), .done_ioc(done_ioc),
        .fetch_valid(fetch_valid), .done_acc(done_acc),
        .free_step(free_step), .pend(pend), .err(err), .irq(irq)
    );

    // Fetch index steps by one per accepted completion
    always_comb fetch_step = {{IDX_W{1'b0}}, done_acc};

    dbl_ptr #(.IDX_W(IDX_W)) u_fetch_ptr (
        .clk(clk), .rst_n(rst_n), .step(fetch_step), .size(q_size), .ptr(fetch_idx)
    );

    dbl_ptr #(.IDX_W(IDX_W)) u_rel_ptr (
        .clk(clk), .rst_n(rst_n), .step(free_step), .size(q_size), .ptr(rel_idx)
    );

    // Status word packing
    always_comb begin
        stat_word = 32'(pend) << STAT_PEND_LSB;
        stat_word = stat_word | (32'(rel_idx) << STAT_IDX_LSB);
    end

    // Register read mux
    always_comb begin
        case (rd_addr)
            REG_SIZE: rd_data = 32'(q_size);
            REG_STAT: rd_data = stat_word;
            REG_RUN:  rd_data = {31'd0, stopped};
            REG_ERR:  rd_data = {30'd0, err};
            default:  rd_data = 32'd0;
        endcase
    end

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend != '0)); // R9
    AST_IDLE_DONE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_done && !fetch_valid) |=> $stable(fetch_idx)); // R2
endmodule

// File: tb/dring_doorbell_tb.sv
module dring_doorbell_tb;
    localparam int IDX_W = 13;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [31:0]      wr_data = '0;
    logic [2:0]       rd_addr = '0;
    logic [31:0]      rd_data;
    logic             fetch_valid;
    logic [IDX_W-1:0] fetch_idx;
    logic             desc_done = 1'b0;
    logic             done_ioc = 1'b0;
    logic             irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    dring_doorbell #(.IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .fetch_valid(fetch_valid), .fetch_idx(fetch_idx),
        .desc_done(desc_done), .done_ioc(done_ioc), .irq(irq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            failures = failures + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pulse_done(input logic ioc);
        @(negedge clk);
        desc_done = 1'b1; done_ioc = ioc;
        @(negedge clk);
        desc_done = 1'b0; done_ioc = 1'b0;
    endtask

    function automatic logic [31:0] stat(input int p, input int idx);
        return 32'(p) | (32'(idx) << 16);
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        reg_rd(3'd4, v); check("R1 stopped", v, 32'd1);
        reg_rd(3'd3, v); check("R1 status", v, 32'd0);
        reg_rd(3'd5, v); check("R1 error", v, 32'd0);
        reg_rd(3'd0, v); check("R1 size", v, 32'd0);
        check("R1 fetch_valid", {31'd0, fetch_valid}, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_stop_gate();
        logic [31:0] v;
        reg_wr(3'd0, 32'd8);
        reg_wr(3'd1, 32'd3);
        check("R10 no fetch while stopped", {31'd0, fetch_valid}, 32'd0);
        pulse_done(1'b0);
        reg_rd(3'd3, v); check("R2 done ignored while stopped", v, 32'd0);
        reg_wr(3'd4, 32'd0);
        reg_rd(3'd4, v); check("R10 running", v, 32'd0);
        check("R2 fetch_valid", {31'd0, fetch_valid}, 32'd1);
        check("R2 fetch_idx", 32'(fetch_idx), 32'd0);
    endtask

    task automatic t_complete();
        logic [31:0] v;
        pulse_done(1'b0);
        pulse_done(1'b0);
        check("R3 fetch_idx", 32'(fetch_idx), 32'd2);
        reg_rd(3'd3, v); check("R4 status after two", v, stat(2, 0));
        reg_wr(3'd2, 32'd1);
        reg_rd(3'd3, v); check("R5 release one", v, stat(1, 1));
        pulse_done(1'b0);
        check("R2 out of work", {31'd0, fetch_valid}, 32'd0);
        pulse_done(1'b0);
        reg_rd(3'd3, v); check("R2 idle done ignored", v, stat(2, 1));
        check("R2 idle fetch_idx", 32'(fetch_idx), 32'd3);
    endtask

    task automatic t_clamp();
        logic [31:0] v;
        reg_wr(3'd2, 32'd5);
        reg_rd(3'd3, v); check("R7 clamped release", v, stat(0, 3));
        reg_rd(3'd5, v); check("R7 error bit1", v, 32'd2);
    endtask

    task automatic t_saturate_wrap();
        logic [31:0] v;
        reg_wr(3'd1, 32'd7);
        reg_rd(3'd5, v); check("R8 no overflow yet", v, 32'd2);
        reg_wr(3'd1, 32'd3);
        reg_rd(3'd5, v); check("R8 overflow sticky", v, 32'd3);
        for (int i = 0; i < 8; i++) pulse_done(1'b0);
        check("R6 fetch wrap", 32'(fetch_idx), 32'd3);
        check("R8 saturated to eight", {31'd0, fetch_valid}, 32'd0);
        reg_rd(3'd3, v); check("R8 pending eight", v, stat(8, 3));
        reg_wr(3'd1, 32'd1);
        check("R8 full ring rejects add", {31'd0, fetch_valid}, 32'd0);
        reg_wr(3'd2, 32'd6);
        reg_rd(3'd3, v); check("R6 release wrap", v, stat(2, 1));
    endtask

    task automatic t_irq();
        logic [31:0] v;
        check("R9 no irq without request", {31'd0, irq}, 32'd0);
        reg_wr(3'd1, 32'd1);
        pulse_done(1'b1);
        check("R9 irq raised", {31'd0, irq}, 32'd1);
        reg_wr(3'd2, 32'd2);
        check("R9 irq held while pending", {31'd0, irq}, 32'd1);
        reg_wr(3'd2, 32'd1);
        check("R9 irq drops at zero", {31'd0, irq}, 32'd0);
        reg_rd(3'd3, v); check("R5 status after drain", v, stat(0, 4));
        check("R3 fetch_idx after irq", 32'(fetch_idx), 32'd4);
    endtask

    task automatic t_stop_size();
        logic [31:0] v;
        reg_wr(3'd4, 32'd7);
        reg_rd(3'd4, v); check("R10 stopped readback", v, 32'd1);
        reg_wr(3'd1, 32'd1);
        check("R10 stopped no fetch", {31'd0, fetch_valid}, 32'd0);
        reg_wr(3'd0, 32'd20000);
        reg_rd(3'd0, v); check("R11 size clamp", v, 32'd8192);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stop_gate();
        t_complete();
        t_clamp();
        t_saturate_wrap();
        t_irq();
        t_stop_size();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule